// File: doc/BRIEF.md
# Receive Sample Concealment Unit

This block sits between the subframe decoder of a digital audio receiver and the serial audio output stage. Each decoded subframe arrives with a valid strobe, an A/B indicator, a sample word and an error flag. The block turns these subframes into left/right output pairs. When a subframe is flagged as errored, a 2-bit policy input chooses what reaches the output: the last clean sample, silence, or the damaged sample unchanged.

A mute input forces both output words to zero. Mute acts on the concealed result, so the output strobe keeps its normal timing. A mono input treats the A and B subframes as consecutive samples of a single channel. Each of those samples is then copied to both outputs, so output pairs come at twice the stereo rate.

Top module: `aud_conceal_top`

## Requirements
- R1: After reset, `outValid` is 0, both output words are 0, and every last-clean history register holds zero. An errored first sample under policy 00 therefore produces 0.
- R2: With `monoEn`=0, a subframe with `inSubB`=0 (A) is held for the left output and does not raise `outValid`. A subframe with `inSubB`=1 (B) raises `outValid` for exactly one cycle, in the cycle after it is accepted, with left = the concealed A value and right = the concealed B value.
- R3: With `holdSel`=00, an errored subframe is replaced by the last error-free sample of the same history.
- R4: With `holdSel`=01, an errored subframe is replaced by an all-zero word.
- R5: With `holdSel`=10, an errored subframe passes through unchanged.
- R6: `holdSel`=11 behaves exactly like 00.
- R7: A history register loads only from error-free subframes. An errored subframe never changes it, whatever the policy.
- R8: In stereo mode, A and B keep separate histories. In mono mode, a single history is shared by both subframe kinds.
- R9: With `muteEn`=1, both output words are zero while `outValid` keeps its normal timing. Histories keep updating during mute.
- R10: With `monoEn`=1, every accepted subframe raises `outValid` one cycle later, with `outLeft` equal to `outRight` equal to the concealed sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Subframe valid strobe |
| inSubB | input | 1 | 0 = subframe A, 1 = subframe B |
| inSample | input | SAMPLE_W | Decoded sample word |
| inErr | input | 1 | Receive error flag for this subframe |
| holdSel | input | 2 | Error policy: 00 hold, 01 zero, 10 pass, 11 as 00 |
| muteEn | input | 1 | Force output words to zero |
| monoEn | input | 1 | Single-channel mode with doubled rate |
| outValid | output | 1 | One-cycle output pair strobe |
| outLeft | output | SAMPLE_W | Left output sample |
| outRight | output | SAMPLE_W | Right output sample |

## Verification
Concealment and mute can both act on the same subframe. The bench sweeps every policy code against every 4-bit error pattern over two frames, and runs each sweep once with mute off and once with mute on. A reference model in the bench tracks the histories arithmetically. It expects zero words whenever mute is on, and it checks afterwards that history updates made under mute still show up once mute is released. Mono and stereo are each swept after their own reset, and directed sequences separate shared histories from per-channel ones.

// File: rtl/aud_conceal_pkg.sv
package aud_conceal_pkg;

  localparam int CH_N = 2;

  typedef enum logic [1:0] {
    HOLD_LAST = 2'b00,
    HOLD_ZERO = 2'b01,
    HOLD_PASS = 2'b10,
    HOLD_RSVD = 2'b11
  } holdPol_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadPend;   // capture concealed A for later left output
    logic emit;       // produce an output pair next cycle
    logic dupCur;     // mono: left takes current sample too
    logic selRight;   // history select for concealment
    logic updLeft;    // load history 0
    logic updRight;   // load history 1
  } strobes_t;

endpackage

// File: rtl/aud_conceal_ctrl.sv
module aud_conceal_ctrl
  import aud_conceal_pkg::*;
(
  input  logic     inValid,
  input  logic     inSubB,
  input  logic     inErr,
  input  logic     monoEn,
  output strobes_t strb
);

  logic clean;
  assign clean = ~inErr;

  always_comb begin
    strb = '0;
    if (inValid) begin
      if (monoEn) begin
        strb.emit    = 1'b1;
        strb.dupCur  = 1'b1;
        strb.updLeft = clean;      // shared history lives in slot 0
      end else if (inSubB) begin
        strb.emit     = 1'b1;
        strb.selRight = 1'b1;
        strb.updRight = clean;
      end else begin
        strb.loadPend = 1'b1;
        strb.updLeft  = clean;
      end
    end
  end

endmodule

// File: rtl/aud_conceal_dp.sv
module aud_conceal_dp
  import aud_conceal_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  strobes_t            strb,
  input  logic [SAMPLE_W-1:0] inSample,
  input  logic                inErr,
  input  logic [1:0]          holdSel,
  input  logic                muteEn,
  output logic                outValid,
  output logic [SAMPLE_W-1:0] outLeft,
  output logic [SAMPLE_W-1:0] outRight
);

  localparam logic [SAMPLE_W-1:0] ZERO_W = '0;

  logic [SAMPLE_W-1:0] hist [CH_N];
  logic [CH_N-1:0]     updEn;
  logic [SAMPLE_W-1:0] histSel;
  logic [SAMPLE_W-1:0] concVal;
  logic [SAMPLE_W-1:0] pendLeft;
  logic [SAMPLE_W-1:0] leftSrc;
  holdPol_t            pol;

  assign updEn   = {strb.updRight, strb.updLeft};
  assign histSel = strb.selRight ? hist[1] : hist[0];
  assign pol     = holdPol_t'(holdSel);

  for (genvar g = 0; g < CH_N; g++) begin : g_hist
    always_ff @(posedge clk) begin
      if (!rst_n)        hist[g] <= ZERO_W;
      else if (updEn[g]) hist[g] <= inSample;
    end
  end

  always_comb begin
    concVal = inSample;
    if (inErr) begin
      unique case (pol)
        HOLD_ZERO: concVal = ZERO_W;
        HOLD_PASS: concVal = inSample;
        default:   concVal = histSel;   // HOLD_LAST and reserved code
      endcase
    end
  end

  assign leftSrc = strb.dupCur ? concVal : pendLeft;

  always_ff @(posedge clk) begin
    if (!rst_n)             pendLeft <= ZERO_W;
    else if (strb.loadPend) pendLeft <= concVal;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outLeft  <= ZERO_W;
      outRight <= ZERO_W;
    end else begin
      outValid <= strb.emit;
      if (strb.emit) begin
        outLeft  <= muteEn ? ZERO_W : leftSrc;
        outRight <= muteEn ? ZERO_W : concVal;
      end
    end
  end

endmodule

// File: rtl/aud_conceal_top.sv
module aud_conceal_top
  import aud_conceal_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inValid,
  input  logic                inSubB,
  input  logic [SAMPLE_W-1:0] inSample,
  input  logic                inErr,
  input  logic [1:0]          holdSel,
  input  logic                muteEn,
  input  logic                monoEn,
  output logic                outValid,
  output logic [SAMPLE_W-1:0] outLeft,
  output logic [SAMPLE_W-1:0] outRight
);

  strobes_t strb;

  aud_conceal_ctrl ctrl_i (
    .inValid (inValid),
    .inSubB  (inSubB),
    .inErr   (inErr),
    .monoEn  (monoEn),
    .strb    (strb)
  );

  aud_conceal_dp #(.SAMPLE_W(SAMPLE_W)) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .inSample (inSample),
    .inErr    (inErr),
    .holdSel  (holdSel),
    .muteEn   (muteEn),
    .outValid (outValid),
    .outLeft  (outLeft),
    .outRight (outRight)
  );

endmodule

// File: rtl/aud_conceal_chk.sv
module aud_conceal_chk #(
  parameter int SAMPLE_W = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                inValid,
  input logic                inSubB,
  input logic [SAMPLE_W-1:0] inSample,
  input logic                inErr,
  input logic [1:0]          holdSel,
  input logic                muteEn,
  input logic                monoEn,
  input logic                outValid,
  input logic [SAMPLE_W-1:0] outLeft,
  input logic [SAMPLE_W-1:0] outRight
);

  logic emitIn;
  assign emitIn = inValid && (monoEn || inSubB);

  p_pair_after_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && inSubB && !monoEn |=> outValid);

  p_no_pair_on_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && !inSubB && !monoEn |=> !outValid);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);

  p_zero_policy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    emitIn && inErr && holdSel == 2'b01 |=> outRight == '0);

  p_pass_policy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    emitIn && inErr && holdSel == 2'b10 && !muteEn |=> outRight == $past(inSample));

  p_clean_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    emitIn && !inErr && !muteEn |=> outRight == $past(inSample));

  p_mute_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    emitIn && muteEn |=> outValid && outLeft == '0 && outRight == '0);

  p_mono_dup_r10: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && monoEn |=> outValid && outLeft == outRight);

endmodule

bind aud_conceal_top aud_conceal_chk #(.SAMPLE_W(SAMPLE_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .inValid  (inValid),
  .inSubB   (inSubB),
  .inSample (inSample),
  .inErr    (inErr),
  .holdSel  (holdSel),
  .muteEn   (muteEn),
  .monoEn   (monoEn),
  .outValid (outValid),
  .outLeft  (outLeft),
  .outRight (outRight)
);

// File: tb/aud_conceal_tb.sv
`timescale 1ns/1ps
module aud_conceal_top_tb_top;

  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         inValid = 1'b0;
  logic         inSubB = 1'b0;
  logic [W-1:0] inSample = '0;
  logic         inErr = 1'b0;
  logic [1:0]   holdSel = 2'b00;
  logic         muteEn = 1'b0;
  logic         monoEn = 1'b0;
  logic         outValid;
  logic [W-1:0] outLeft, outRight;

  always #2 clk = ~clk;

  aud_conceal_top #(.SAMPLE_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inSubB(inSubB),
    .inSample(inSample), .inErr(inErr), .holdSel(holdSel),
    .muteEn(muteEn), .monoEn(monoEn), .outValid(outValid),
    .outLeft(outLeft), .outRight(outRight));

  int nVec = 0;
  int nBad = 0;
  bit done = 1'b0;

  // reference model state
  logic [W-1:0] mL, mR, mH, mPend;
  string forceTag = "";

  task automatic chk(input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic doReset();
    rst_n = 1'b0;
    inValid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mL = '0; mR = '0; mH = '0; mPend = '0;
  endtask

  task automatic sub(input bit b, input logic [W-1:0] s, input bit e);
    logic [W-1:0] h, conc, expL, expR;
    bit expV;
    string tg;
    h = monoEn ? mH : (b ? mR : mL);
    if (!e)                  conc = s;
    else if (holdSel == 2'd1) conc = '0;
    else if (holdSel == 2'd2) conc = s;
    else                      conc = h;
    expV = monoEn || b;
    expL = muteEn ? '0 : (monoEn ? conc : mPend);
    expR = muteEn ? '0 : conc;
    if (forceTag != "")    tg = forceTag;
    else if (muteEn)       tg = "R9";
    else if (e)            tg = (holdSel == 0) ? "R3" : (holdSel == 1) ? "R4" :
                                (holdSel == 2) ? "R5" : "R6";
    else if (monoEn)       tg = "R10";
    else                   tg = "R2";
    @(negedge clk);
    inValid = 1'b1; inSubB = b; inSample = s; inErr = e;
    @(negedge clk);
    inValid = 1'b0;
    chk(tg, "outValid", {{(W-1){1'b0}}, outValid}, {{(W-1){1'b0}}, expV});
    if (expV) begin
      chk(tg, "outLeft", outLeft, expL);
      chk(tg, "outRight", outRight, expR);
    end
    if (!e) begin
      if (monoEn) mH = s;
      else if (b) mR = s;
      else        mL = s;
    end
    if (!monoEn && !b) mPend = conc;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nVec++; nBad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1: reset state
    chk("R1", "outValid", {{(W-1){1'b0}}, outValid}, '0);
    chk("R1", "outLeft", outLeft, '0);
    chk("R1", "outRight", outRight, '0);
    forceTag = "R1";
    sub(1'b0, 24'h123456, 1'b1);
    sub(1'b1, 24'h654321, 1'b1);
    forceTag = "";

    // sweep: mode x policy x mute x error pattern
    for (int mo = 0; mo < 2; mo++) begin
      for (int hp = 0; hp < 4; hp++) begin
        monoEn = mo[0]; holdSel = hp[1:0]; muteEn = 1'b0;
        doReset();
        for (int mu = 0; mu < 2; mu++) begin
          muteEn = mu[0];
          for (int pat = 0; pat < 16; pat++) begin
            for (int k = 0; k < 4; k++) begin
              sub(k[0], W'(((mo * 8 + hp) * 32 + mu * 16 + pat) * 4099 + k * 257 + 1),
                  pat[k]);
            end
          end
        end
        // R9: history updated under mute is used once mute is released
        muteEn = 1'b0;
        for (int k = 0; k < 4; k++) sub(k[0], W'(24'hA5A000 + k), 1'b1);
      end
    end

    // R8: shared history in mono, split in stereo
    monoEn = 1'b1; holdSel = 2'b00; muteEn = 1'b0;
    doReset();
    forceTag = "R8";
    sub(1'b0, 24'h000005, 1'b0);
    sub(1'b1, 24'h0000EE, 1'b1);   // expects 5 from shared history
    monoEn = 1'b0;
    doReset();
    sub(1'b0, 24'h000100, 1'b0);
    sub(1'b1, 24'h000200, 1'b0);
    sub(1'b0, 24'h0F0F0F, 1'b1);   // left holds 100
    sub(1'b1, 24'h0E0E0E, 1'b1);   // right holds 200

    // R7: errored samples never load history, even under pass policy
    forceTag = "R7";
    holdSel = 2'b10;
    sub(1'b0, 24'h222222, 1'b1);
    sub(1'b1, 24'h333333, 1'b1);
    holdSel = 2'b00;
    sub(1'b0, 24'h444444, 1'b1);   // still 100
    sub(1'b1, 24'h555555, 1'b1);   // still 200
    forceTag = "";

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule